// File: doc/BRIEF.md
# Single-Step Shift and Rotate Unit with Condition Flags

This unit performs one-position shifts, rotates and bitwise inversion for a small processor datapath. Each request supplies a 32-bit operand word, a size code that picks the active field (the low 8, 16 or 32 bits), an operation code and the current carry flag. The unit returns the transformed word along with negative, zero, overflow and carry flags.

The carry and the sign position both move with the selected size. Bits of the word above the active field are passed through untouched, so a byte or halfword operation can be merged straight back into a wider register. Results and flags are captured in an output register on the clock edge after a request is presented, and a valid strobe marks them.

Top module: `shift_flag_unit`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `out_valid` is 0 and `out_result`, `out_n`, `out_z`, `out_v` and `out_c` are all 0.
- R2: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. When `in_valid` is low, the result and flag outputs keep their previous values.
- R3: Size code 0 selects an 8-bit field, code 1 a 16-bit field, and codes 2 and 3 the full 32-bit word. Output bits above the active field equal the operand bits there.
- R4: Op codes 0 (logical left) and 2 (arithmetic left) shift the field left by one with a zero fill. The old field MSB goes to C.
- R5: Op code 1 (logical right) shifts the field right by one with a zero fill at the MSB. The old bit 0 goes to C.
- R6: Op code 3 (arithmetic right) shifts right by one and keeps the field MSB unchanged. The old bit 0 goes to C.
- R7: Op code 4 rotates left, copying the old MSB into both bit 0 and C. Op code 5 rotates right, copying the old bit 0 into both the MSB and C.
- R8: Op code 6 rotates left through carry: the incoming carry goes to bit 0 and the old MSB goes to C. Op code 7 rotates right through carry: the incoming carry goes to the MSB and the old bit 0 goes to C.
- R9: Op code 8 inverts every bit of the field and leaves C equal to the incoming carry.
- R10: For every operation, N is the result field's MSB, Z is 1 exactly when the result field is zero, and V is 0.
- R11: Op codes 9 to 15 pass the operand through unchanged, leave C equal to the incoming carry, and set N and Z from the operand field.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| in_opnd | input | 32 | Operand word |
| in_size | input | 2 | Active field size code |
| in_op | input | 4 | Operation code |
| in_carry | input | 1 | Incoming carry flag |
| out_valid | output | 1 | Result strobe, one cycle after request |
| out_result | output | 32 | Result word |
| out_n | output | 1 | Negative flag |
| out_z | output | 1 | Zero flag |
| out_v | output | 1 | Overflow flag |
| out_c | output | 1 | Carry flag |

## Verification
The bench builds the unit with its default 32-bit word and 8/16-bit sub-fields. That configuration is small enough to sweep every operation code, reserved codes included, across all four size codes, both carry values and a dozen operand patterns. The operand set places ones and zeros exactly at bit 0, bit 7, bit 15 and bit 31, and includes values with ones above the field. This exercises carry-out at each field boundary, sign retention, zero detection and the untouched upper bits in every size. Expected words come from multiply, divide and modulo arithmetic at the field's width.

// File: rtl/shift_pkg.sv
package shift_pkg;

    typedef enum logic [3:0] {
        OP_LSL  = 4'd0,
        OP_LSR  = 4'd1,
        OP_ASL  = 4'd2,
        OP_ASR  = 4'd3,
        OP_ROL  = 4'd4,
        OP_ROR  = 4'd5,
        OP_RCL  = 4'd6,
        OP_RCR  = 4'd7,
        OP_INV  = 4'd8
    } shu_op_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_WIDE = 2'd3
    } shu_size_e;

endpackage

// File: rtl/shu_size_decode.sv
module shu_size_decode #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int HALF_W = 16
) (
    input  shift_pkg::shu_size_e size,
    output logic [WORD_W-1:0]    low_mask,
    output logic [WORD_W-1:0]    top_bit
);
    import shift_pkg::*;

    localparam logic [WORD_W-1:0] ONE       = {{(WORD_W-1){1'b0}}, 1'b1};
    localparam logic [WORD_W-1:0] BYTE_MASK = (ONE << BYTE_W) - ONE;
    localparam logic [WORD_W-1:0] HALF_MASK = (ONE << HALF_W) - ONE;
    localparam logic [WORD_W-1:0] BYTE_TOP  = ONE << (BYTE_W - 1);
    localparam logic [WORD_W-1:0] HALF_TOP  = ONE << (HALF_W - 1);
    localparam logic [WORD_W-1:0] WORD_TOP  = ONE << (WORD_W - 1);

    always_comb begin
        case (size)
            SZ_BYTE: begin
                low_mask = BYTE_MASK;
                top_bit  = BYTE_TOP;
            end
            SZ_HALF: begin
                low_mask = HALF_MASK;
                top_bit  = HALF_TOP;
            end
            default: begin
                low_mask = '1;
                top_bit  = WORD_TOP;
            end
        endcase
    end

    always_comb begin
        assert ($onehot(top_bit) && ((top_bit & ~low_mask) == '0))
            else $error("p_top_in_field_r3: top bit outside active field");
    end

endmodule

// File: rtl/shu_op_core.sv
module shu_op_core #(
    parameter int WORD_W = 32
) (
    input  shift_pkg::shu_op_e op,
    input  logic [WORD_W-1:0]  fld,
    input  logic [WORD_W-1:0]  low_mask,
    input  logic [WORD_W-1:0]  top_bit,
    input  logic               cin,
    output logic [WORD_W-1:0]  res,
    output logic               cout
);
    import shift_pkg::*;

    logic [WORD_W-1:0] up_d;
    logic [WORD_W-1:0] dn_d;
    logic              old_top;
    logic              old_low;

    always_comb begin
        up_d    = (fld << 1) & low_mask;
        dn_d    = fld >> 1;
        old_top = |(fld & top_bit);
        old_low = fld[0];
        res     = fld;
        cout    = cin;
        case (op)
            OP_LSL, OP_ASL: begin
                res  = up_d;
                cout = old_top;
            end
            OP_LSR: begin
                res  = dn_d;
                cout = old_low;
            end
            OP_ASR: begin
                res  = dn_d | (old_top ? top_bit : '0);
                cout = old_low;
            end
            OP_ROL: begin
                res  = up_d | {{(WORD_W-1){1'b0}}, old_top};
                cout = old_top;
            end
            OP_ROR: begin
                res  = dn_d | (old_low ? top_bit : '0);
                cout = old_low;
            end
            OP_RCL: begin
                res  = up_d | {{(WORD_W-1){1'b0}}, cin};
                cout = old_top;
            end
            OP_RCR: begin
                res  = dn_d | (cin ? top_bit : '0);
                cout = old_low;
            end
            OP_INV: begin
                res  = ~fld & low_mask;
                cout = cin;
            end
            default: begin
                res  = fld;
                cout = cin;
            end
        endcase
    end

endmodule

// File: rtl/shift_flag_unit.sv
module shift_flag_unit #(
    parameter int WORD_W = 32,
    parameter int BYTE_W = 8,
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [WORD_W-1:0] in_opnd,
    input  logic [1:0]        in_size,
    input  logic [3:0]        in_op,
    input  logic              in_carry,
    output logic              out_valid,
    output logic [WORD_W-1:0] out_result,
    output logic              out_n,
    output logic              out_z,
    output logic              out_v,
    output logic              out_c
);
    import shift_pkg::*;

    typedef struct packed {
        logic              valid;
        logic [WORD_W-1:0] result;
        logic              n;
        logic              z;
        logic              v;
        logic              c;
    } stage_t;

    stage_t st_d, st_q;

    logic [WORD_W-1:0] low_mask_d;
    logic [WORD_W-1:0] top_bit_d;
    logic [WORD_W-1:0] field_d;
    logic [WORD_W-1:0] core_res_d;
    logic              core_c_d;

    shu_size_decode #(
        .WORD_W (WORD_W),
        .BYTE_W (BYTE_W),
        .HALF_W (HALF_W)
    ) u_size (
        .size     (shu_size_e'(in_size)),
        .low_mask (low_mask_d),
        .top_bit  (top_bit_d)
    );

    assign field_d = in_opnd & low_mask_d;

    shu_op_core #(
        .WORD_W (WORD_W)
    ) u_core (
        .op       (shu_op_e'(in_op)),
        .fld      (field_d),
        .low_mask (low_mask_d),
        .top_bit  (top_bit_d),
        .cin      (in_carry),
        .res      (core_res_d),
        .cout     (core_c_d)
    );

    always_comb begin
        st_d       = st_q;
        st_d.valid = in_valid;
        if (in_valid) begin
            st_d.result = (in_opnd & ~low_mask_d) | core_res_d;
            st_d.n      = |(core_res_d & top_bit_d);
            st_d.z      = (core_res_d == '0);
            st_d.v      = 1'b0;
            st_d.c      = core_c_d;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid  = st_q.valid;
    assign out_result = st_q.result;
    assign out_n      = st_q.n;
    assign out_z      = st_q.z;
    assign out_v      = st_q.v;
    assign out_c      = st_q.c;

    p_valid_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_result) && $stable(out_c)));

    p_byte_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_size == 2'd0) |=> (out_result[WORD_W-1:BYTE_W] == $past(in_opnd[WORD_W-1:BYTE_W])));

    p_inv_carry_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd8) |=> (out_c == $past(in_carry)));

    p_rcl_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_op == 4'd6) |=> (out_result[0] == $past(in_carry)));

    p_v_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> !out_v);

endmodule

// File: tb/shift_flag_unit_test.sv
module shift_flag_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_opnd = '0;
    logic [1:0]  in_size = '0;
    logic [3:0]  in_op = '0;
    logic        in_carry = 1'b0;
    logic        out_valid;
    logic [31:0] out_result;
    logic        out_n, out_z, out_v, out_c;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    shift_flag_unit uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .in_opnd    (in_opnd),
        .in_size    (in_size),
        .in_op      (in_op),
        .in_carry   (in_carry),
        .out_valid  (out_valid),
        .out_result (out_result),
        .out_n      (out_n),
        .out_z      (out_z),
        .out_v      (out_v),
        .out_c      (out_c)
    );

    localparam logic [31:0] PATS [12] = '{
        32'h0000_0000, 32'hFFFF_FFFF, 32'h8000_0001, 32'h0000_0080,
        32'h0000_8000, 32'h7F7F_7F7F, 32'h1234_5678, 32'hA5A5_5AA5,
        32'h0000_0001, 32'hDEAD_BEEF, 32'h0000_00FF, 32'h0001_0000
    };

    // expected {valid, result, n, z, v, c}
    function automatic logic [36:0] model(input logic [31:0] x, input int sz,
                                          input int op, input bit cin);
        longint w, md, a, top, low, r, hi;
        bit c;
        w   = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        md  = longint'(1) << w;
        a   = longint'(x) % md;
        hi  = longint'(x) - a;
        top = a / (md / 2);
        low = a % 2;
        c   = cin;
        case (op)
            0, 2: begin r = (a * 2) % md;                 c = bit'(top); end
            1:    begin r = a / 2;                        c = bit'(low); end
            3:    begin r = a / 2 + top * (md / 2);       c = bit'(low); end
            4:    begin r = (a * 2) % md + top;           c = bit'(top); end
            5:    begin r = a / 2 + low * (md / 2);       c = bit'(low); end
            6:    begin r = (a * 2) % md + longint'(cin); c = bit'(top); end
            7:    begin r = a / 2 + longint'(cin) * (md / 2); c = bit'(low); end
            8:    begin r = (md - 1) - a; end
            default: r = a;
        endcase
        model = {1'b1, 32'(hi + r), bit'(r / (md / 2)), (r == 0), 1'b0, c};
    endfunction

    function automatic string tag_of(input int op);
        case (op)
            0, 2: tag_of = "R4";
            1:    tag_of = "R5";
            3:    tag_of = "R6";
            4, 5: tag_of = "R7";
            6, 7: tag_of = "R8";
            8:    tag_of = "R9";
            default: tag_of = "R11";
        endcase
    endfunction

    task automatic check(input string req, input logic [36:0] got, input logic [36:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    function automatic logic [36:0] outs();
        outs = {out_valid, out_result, out_n, out_z, out_v, out_c};
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [36:0] exp;
        logic [36:0] last;
        repeat (3) @(negedge clk);
        check("R1 in reset", outs(), '0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 after reset", outs(), '0);

        for (int op = 0; op < 16; op++) begin
            for (int sz = 0; sz < 4; sz++) begin
                for (int ci = 0; ci < 2; ci++) begin
                    for (int p = 0; p < 12; p++) begin
                        in_valid = 1'b1;
                        in_opnd  = PATS[p];
                        in_size  = 2'(sz);
                        in_op    = 4'(op);
                        in_carry = ci[0];
                        exp = model(PATS[p], sz, op, ci[0]);
                        @(negedge clk);
                        // R3 R10 covered by every vector: upper bits, N, Z, V
                        check($sformatf("%s/R3/R10 op=%0d size=%0d cin=%0d opnd=%h",
                                        tag_of(op), op, sz, ci, PATS[p]), outs(), exp);
                    end
                end
            end
        end

        // R2: idle cycles hold result and flags, valid drops
        last = outs();
        in_valid = 1'b0;
        in_opnd  = 32'h5555_AAAA;
        in_op    = 4'd8;
        in_carry = ~last[0];
        @(negedge clk);
        check("R2 idle hold", outs(), {1'b0, last[35:0]});
        @(negedge clk);
        check("R2 idle hold second cycle", outs(), {1'b0, last[35:0]});

        // R2: single request after idle, then idle again
        in_valid = 1'b1;
        in_opnd  = 32'h0000_0081;
        in_size  = 2'd0;
        in_op    = 4'd3;
        in_carry = 1'b0;
        exp = model(32'h0000_0081, 0, 3, 1'b0);
        @(negedge clk);
        in_valid = 1'b0;
        check("R2 R6 single request", outs(), exp);
        @(negedge clk);
        check("R2 valid drops after single request", outs(), {1'b0, exp[35:0]});

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule